// File: doc/BRIEF.md
# Return Address Stack

This block holds the return addresses of a processor core in a dedicated storage of its own, apart from program and data memory. With the default parameters it keeps 31 entries of 21 bits each and uses a 5-bit pointer. Pointer value 0 means the stack is empty and has no storage behind it. Pointer values 1 to 31 each select one stored entry.

A push comes from a call, a relative call or an interrupt acknowledge. It first moves the pointer up by one and then stores the supplied program counter value in the newly selected entry. A pop comes from a return, a return with a literal or a return from interrupt. It hands the selected entry to the program counter and then moves the pointer down by one. Decoding these events is done outside the block, which sees only a push request and a pop request.

Software can read and write the pointer. It can also read the current top entry through a window of three byte lanes and patch any of those lanes. The block reports when the stack is full. It also keeps sticky overflow and underflow flags, each of which stays set until software clears it.

Top module: `ret_stack`

## Requirements
- R1: While reset is high, and in the first cycle after it, the pointer is 0, full, overflow, underflow and pop_valid are 0, and tos_rdata is 0.
- R2: A push with the pointer below 31 raises the pointer by one at the clock edge. From the next cycle, tos_rdata shows the ret_pc value sampled at that edge.
- R3: A pop with the pointer above 0 lowers the pointer by one. In the next cycle pop_valid is 1 and pop_addr equals the entry that was on top before the pop. pop_valid is 1 only in the cycle right after an accepted pop.
- R4: A push with the pointer at 31 sets overflow. The pointer and the stored entries stay as they were.
- R5: A pop with the pointer at 0 sets underflow and leaves the pointer at 0. In the next cycle pop_valid is 1 and pop_addr is 0.
- R6: full is 1 exactly when the pointer output equals 31.
- R7: Overflow and underflow are sticky. Each clears only when its own clear input is high. If a clear and a new overflow or underflow event fall in the same cycle, the flag stays set.
- R8: tos_rdata shows the top entry zero-extended to 24 bits: entry bits 7:0 in lane 0 (bits 7:0), bits 15:8 in lane 1 (bits 15:8), and bits 20:16 in bits 20:16, with bits 23:21 at 0. When the pointer is 0, tos_rdata is 0.
- R9: tos_we bit 0 writes tos_wdata into entry bits 7:0. Bit 1 writes tos_wdata into bits 15:8. Bit 2 writes tos_wdata bits 4:0 into bits 20:16. Lanes whose enable is low keep their value. A lane write while the pointer is 0 changes no entry.
- R10: When ptr_we is high, the pointer takes ptr_wdata, which may be any value from 0 to 31. The pointer output and the top-of-stack window then follow the new pointer.
- R11: When several requests arrive in one cycle, only the highest-priority one takes effect. The order is pointer write, then push, then pop, then lane write.
- R12: After 31 pushes of distinct values from an empty stack, 31 pops return those values in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push_req | input | 1 | Push ret_pc (call, relative call or interrupt acknowledge) |
| pop_req | input | 1 | Pop the top entry (any return type) |
| ret_pc | input | 21 | Address of the next instruction, stored on a push |
| pop_valid | output | 1 | pop_addr carries the result of a pop this cycle |
| pop_addr | output | 21 | Popped address for the program counter |
| ptr_we | input | 1 | Software write of the pointer |
| ptr_wdata | input | 5 | New pointer value |
| ptr | output | 5 | Current pointer |
| tos_we | input | 3 | Byte-lane write enables for the top entry |
| tos_wdata | input | 8 | Byte written into each enabled lane |
| tos_rdata | output | 24 | Top entry, split into three lanes |
| full | output | 1 | Pointer is at 31 |
| ovf | output | 1 | Sticky overflow flag |
| unf | output | 1 | Sticky underflow flag |
| ovf_clr | input | 1 | Clear overflow |
| unf_clr | input | 1 | Clear underflow |

## Verification
The bench builds the block with its default parameters: a 5-bit pointer and 21-bit addresses. With these values a full fill of 31 pushes is short enough to reach both ends of the pointer range in one run, so overflow at 31 and underflow at 0 are each driven repeatedly. The address width leaves a partial upper lane of 5 bits. This checks that the unused lane bits read as zero and that only the low five data bits land in that lane. A behavioural model runs next to the design and is compared every cycle, including cycles where simultaneous requests test the priority order.

// File: rtl/rs_pkg.sv
package rs_pkg;

  // Operation selected for one clock cycle, already resolved by priority.
  typedef enum logic [2:0] {
    OP_IDLE   = 3'd0,
    OP_SETPTR = 3'd1,
    OP_PUSH   = 3'd2,
    OP_POP    = 3'd3,
    OP_PATCH  = 3'd4
  } rs_op_e;

  // Number of byte lanes needed to cover an address of the given width.
  function automatic int unsigned lane_count(input int unsigned addr_w);
    return (addr_w + 7) / 8;
  endfunction

endpackage

// File: rtl/rs_ptr_ctrl.sv
module rs_ptr_ctrl
  import rs_pkg::*;
#(
  parameter int unsigned PTR_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic             pop_req,
  input  logic             ptr_we,
  input  logic [PTR_W-1:0] ptr_wdata,
  input  logic             patch_req,
  input  logic             ovf_clr,
  input  logic             unf_clr,
  output rs_op_e           op,
  output logic [PTR_W-1:0] ptr_q,
  output logic             empty,
  output logic             full_q,
  output logic             ovf_q,
  output logic             unf_q
);

  // Highest pointer value, which is also the number of stored entries.
  localparam logic [PTR_W-1:0] TOP = '1;

  logic             at_top;
  logic [PTR_W-1:0] ptr_d;
  logic             ovf_d;
  logic             unf_d;

  always_comb begin
    at_top = (ptr_q == TOP);
    empty  = (ptr_q == '0);
  end

  // Resolve the requests by priority: pointer write, push, pop, lane write.
  always_comb begin
    if (ptr_we)         op = OP_SETPTR;
    else if (push_req)  op = OP_PUSH;
    else if (pop_req)   op = OP_POP;
    else if (patch_req) op = OP_PATCH;
    else                op = OP_IDLE;
  end

  always_comb begin
    ptr_d = ptr_q;
    unique case (op)
      OP_SETPTR: ptr_d = ptr_wdata;
      OP_PUSH:   if (!at_top) ptr_d = ptr_q + PTR_W'(1);
      OP_POP:    if (!empty)  ptr_d = ptr_q - PTR_W'(1);
      default:   ptr_d = ptr_q;
    endcase
  end

  // A new event wins over a clear arriving in the same cycle.
  always_comb begin
    ovf_d = (ovf_q & ~ovf_clr) | ((op == OP_PUSH) & at_top);
    unf_d = (unf_q & ~unf_clr) | ((op == OP_POP) & empty);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q  <= '0;
      full_q <= 1'b0;
      ovf_q  <= 1'b0;
      unf_q  <= 1'b0;
    end else begin
      ptr_q  <= ptr_d;
      full_q <= (ptr_d == TOP);
      ovf_q  <= ovf_d;
      unf_q  <= unf_d;
    end
  end

endmodule

// File: rtl/rs_store.sv
module rs_store #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned PTR_W  = 5
) (
  input  logic                                   clk,
  input  logic [PTR_W-1:0]                       wr_addr,
  input  logic [rs_pkg::lane_count(ADDR_W)-1:0]  wr_lane,
  input  logic [ADDR_W-1:0]                      wr_data,
  input  logic [PTR_W-1:0]                       rd_addr,
  output logic [ADDR_W-1:0]                      rd_data
);

  localparam int unsigned DEPTH = (1 << PTR_W) - 1;
  localparam int unsigned LANES = rs_pkg::lane_count(ADDR_W);

  // One bank per byte lane, so that a lane write touches only its own bank.
  // Slot 0 has no storage: it is the empty marker.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam int unsigned LO = 8 * g;
    localparam int unsigned LW = (g == LANES - 1) ? (ADDR_W - LO) : 8;

    logic [LW-1:0] bank [1:DEPTH];

    always_ff @(posedge clk) begin
      if (wr_lane[g] && (wr_addr != '0)) begin
        bank[wr_addr] <= wr_data[LO +: LW];
      end
    end

    always_comb begin
      if (rd_addr != '0) rd_data[LO +: LW] = bank[rd_addr];
      else               rd_data[LO +: LW] = '0;
    end
  end

endmodule

// File: rtl/rs_tos_view.sv
module rs_tos_view #(
  parameter int unsigned ADDR_W = 21
) (
  input  logic                                     empty,
  input  logic [ADDR_W-1:0]                        entry,
  output logic [8*rs_pkg::lane_count(ADDR_W)-1:0]  window
);

  localparam int unsigned WIN_W = 8 * rs_pkg::lane_count(ADDR_W);

  // Zero-extend the entry into whole byte lanes; an empty stack reads zero.
  always_comb begin
    if (empty) window = '0;
    else       window = WIN_W'(entry);
  end

endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import rs_pkg::*;
#(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned PTR_W  = 5,
  localparam int unsigned LANES = rs_pkg::lane_count(ADDR_W),
  localparam int unsigned WIN_W = 8 * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_req,
  input  logic              pop_req,
  input  logic [ADDR_W-1:0] ret_pc,
  output logic              pop_valid,
  output logic [ADDR_W-1:0] pop_addr,
  input  logic              ptr_we,
  input  logic [PTR_W-1:0]  ptr_wdata,
  output logic [PTR_W-1:0]  ptr,
  input  logic [LANES-1:0]  tos_we,
  input  logic [7:0]        tos_wdata,
  output logic [WIN_W-1:0]  tos_rdata,
  output logic              full,
  output logic              ovf,
  output logic              unf,
  input  logic              ovf_clr,
  input  logic              unf_clr
);

  rs_op_e              op;
  logic [PTR_W-1:0]    ptr_q;
  logic                empty;
  logic [PTR_W-1:0]    wr_addr;
  logic [LANES-1:0]    wr_lane;
  logic [ADDR_W-1:0]   wr_data;
  logic [ADDR_W-1:0]   top_entry;
  logic [WIN_W-1:0]    byte_rep;
  logic                at_top;

  rs_ptr_ctrl #(.PTR_W(PTR_W)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .push_req  (push_req),
    .pop_req   (pop_req),
    .ptr_we    (ptr_we),
    .ptr_wdata (ptr_wdata),
    .patch_req (|tos_we),
    .ovf_clr   (ovf_clr),
    .unf_clr   (unf_clr),
    .op        (op),
    .ptr_q     (ptr_q),
    .empty     (empty),
    .full_q    (full),
    .ovf_q     (ovf),
    .unf_q     (unf)
  );

  always_comb begin
    at_top   = (ptr_q == '1);
    byte_rep = {LANES{tos_wdata}};
  end

  // Write port: a push fills the slot above the pointer, and a patch
  // updates the selected lanes of the current top slot.
  always_comb begin
    wr_addr = ptr_q;
    wr_lane = '0;
    wr_data = byte_rep[ADDR_W-1:0];
    unique case (op)
      OP_PUSH: begin
        wr_addr = ptr_q + PTR_W'(1);
        wr_data = ret_pc;
        if (!at_top) wr_lane = '1;
      end
      OP_PATCH: begin
        if (!empty) wr_lane = tos_we;
      end
      default: wr_lane = '0;
    endcase
  end

  rs_store #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_store (
    .clk     (clk),
    .wr_addr (wr_addr),
    .wr_lane (wr_lane),
    .wr_data (wr_data),
    .rd_addr (ptr_q),
    .rd_data (top_entry)
  );

  rs_tos_view #(.ADDR_W(ADDR_W)) u_view (
    .empty  (empty),
    .entry  (top_entry),
    .window (tos_rdata)
  );

  // Registered return path to the program counter.
  always_ff @(posedge clk) begin
    if (rst) begin
      pop_valid <= 1'b0;
      pop_addr  <= '0;
    end else begin
      pop_valid <= (op == OP_POP);
      if (op == OP_POP) pop_addr <= empty ? '0 : top_entry;
    end
  end

  assign ptr = ptr_q;

endmodule

// File: rtl/rs_chk.sv
module rs_chk #(
  parameter int unsigned ADDR_W = 21,
  parameter int unsigned PTR_W  = 5,
  parameter int unsigned WIN_W  = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              push_req,
  input logic              pop_req,
  input logic [ADDR_W-1:0] ret_pc,
  input logic              pop_valid,
  input logic [ADDR_W-1:0] pop_addr,
  input logic              ptr_we,
  input logic [PTR_W-1:0]  ptr_wdata,
  input logic [PTR_W-1:0]  ptr,
  input logic [WIN_W-1:0]  tos_rdata,
  input logic              full,
  input logic              ovf,
  input logic              unf,
  input logic              ovf_clr,
  input logic              unf_clr
);

  localparam logic [PTR_W-1:0] TOP = '1;

  // R2
  push_step_chk: assert property (@(posedge clk) disable iff (rst)
    (push_req && !ptr_we && ptr != TOP) |=> (ptr == PTR_W'($past(ptr) + 1'b1)));

  // R2
  push_data_chk: assert property (@(posedge clk) disable iff (rst)
    (push_req && !ptr_we && ptr != TOP) |=> (tos_rdata[ADDR_W-1:0] == $past(ret_pc)));

  // R3
  pop_step_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !ptr_we && ptr != '0)
      |=> (pop_valid && ptr == PTR_W'($past(ptr) - 1'b1)
           && pop_addr == $past(tos_rdata[ADDR_W-1:0])));

  // R3
  no_stray_pop_chk: assert property (@(posedge clk) disable iff (rst)
    !(pop_req && !push_req && !ptr_we) |=> !pop_valid);

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (push_req && !ptr_we && ptr == TOP) |=> (ovf && $stable(ptr) && $stable(tos_rdata)));

  // R5
  no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !push_req && !ptr_we && ptr == '0)
      |=> (unf && pop_valid && pop_addr == '0 && ptr == '0));

  // R6
  full_map_chk: assert property (@(posedge clk) disable iff (rst)
    full == (ptr == TOP));

  // R7
  ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !ovf_clr) |=> ovf);

  // R7
  unf_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (unf && !unf_clr) |=> unf);

  // R8
  empty_window_chk: assert property (@(posedge clk) disable iff (rst)
    (ptr == '0) |-> (tos_rdata == '0));

  // R10
  ptr_load_chk: assert property (@(posedge clk) disable iff (rst)
    ptr_we |=> (ptr == $past(ptr_wdata)));

endmodule

bind ret_stack rs_chk #(
  .ADDR_W (ADDR_W),
  .PTR_W  (PTR_W),
  .WIN_W  (WIN_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .push_req  (push_req),
  .pop_req   (pop_req),
  .ret_pc    (ret_pc),
  .pop_valid (pop_valid),
  .pop_addr  (pop_addr),
  .ptr_we    (ptr_we),
  .ptr_wdata (ptr_wdata),
  .ptr       (ptr),
  .tos_rdata (tos_rdata),
  .full      (full),
  .ovf       (ovf),
  .unf       (unf),
  .ovf_clr   (ovf_clr),
  .unf_clr   (unf_clr)
);

// File: tb/sim_ret_stack.sv
module sim_ret_stack;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 21;
  localparam int PTR_W  = 5;
  localparam int LANES  = 3;
  localparam int DEPTH  = 31;

  logic              clk = 1'b0;
  logic              rst;
  logic              push_req, pop_req, ptr_we, ovf_clr, unf_clr;
  logic [ADDR_W-1:0] ret_pc;
  logic [PTR_W-1:0]  ptr_wdata;
  logic [LANES-1:0]  tos_we;
  logic [7:0]        tos_wdata;
  logic              pop_valid, full, ovf, unf;
  logic [ADDR_W-1:0] pop_addr;
  logic [PTR_W-1:0]  ptr;
  logic [8*LANES-1:0] tos_rdata;

  ret_stack #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u0 (
    .clk(clk), .rst(rst), .push_req(push_req), .pop_req(pop_req), .ret_pc(ret_pc),
    .pop_valid(pop_valid), .pop_addr(pop_addr), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
    .ptr(ptr), .tos_we(tos_we), .tos_wdata(tos_wdata), .tos_rdata(tos_rdata),
    .full(full), .ovf(ovf), .unf(unf), .ovf_clr(ovf_clr), .unf_clr(unf_clr)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Behavioural reference state.
  int m_ptr;
  bit m_ovf, m_unf, m_pv;
  int m_pa;
  int m_mem [1:DEPTH];

  function automatic int m_tos();
    return (m_ptr == 0) ? 0 : m_mem[m_ptr];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic compare(string tag);
    chk(tag, "ptr", int'(ptr), m_ptr);
    chk(tag, "full", int'(full), int'(m_ptr == DEPTH));
    chk(tag, "ovf", int'(ovf), int'(m_ovf));
    chk(tag, "unf", int'(unf), int'(m_unf));
    chk(tag, "pop_valid", int'(pop_valid), int'(m_pv));
    if (m_pv) chk(tag, "pop_addr", int'(pop_addr), m_pa);
    chk(tag, "tos_rdata", int'(tos_rdata), m_tos());
  endtask

  task automatic idle_inputs();
    push_req = 0; pop_req = 0; ptr_we = 0; ovf_clr = 0; unf_clr = 0;
    ret_pc = '0; ptr_wdata = '0; tos_we = '0; tos_wdata = '0;
  endtask

  // One clock: drive at the falling edge, update the model, compare at the next falling edge.
  task automatic step(bit psh, bit pp, bit pwe, int pwd, int twe, int twd,
                      bit oc, bit uc, int pc, string tag);
    push_req = psh; pop_req = pp; ptr_we = pwe; ptr_wdata = pwd[PTR_W-1:0];
    tos_we = twe[LANES-1:0]; tos_wdata = twd[7:0];
    ovf_clr = oc; unf_clr = uc; ret_pc = pc[ADDR_W-1:0];
    m_pv = 0;
    if (oc) m_ovf = 0;
    if (uc) m_unf = 0;
    if (pwe) m_ptr = pwd & 31;
    else if (psh) begin
      if (m_ptr < DEPTH) begin m_ptr++; m_mem[m_ptr] = pc & 'h1FFFFF; end
      else m_ovf = 1;
    end else if (pp) begin
      m_pv = 1;
      if (m_ptr == 0) begin m_pa = 0; m_unf = 1; end
      else begin m_pa = m_mem[m_ptr]; m_ptr--; end
    end else if (twe != 0 && m_ptr != 0) begin
      if (twe & 1) m_mem[m_ptr] = (m_mem[m_ptr] & 'h1FFF00) | (twd & 'hFF);
      if (twe & 2) m_mem[m_ptr] = (m_mem[m_ptr] & 'h1F00FF) | ((twd & 'hFF) << 8);
      if (twe & 4) m_mem[m_ptr] = (m_mem[m_ptr] & 'h00FFFF) | ((twd & 'h1F) << 16);
    end
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    compare(tag);
  endtask

  task automatic push(int pc, string tag);  step(1,0,0,0,0,0,0,0,pc,tag); endtask
  task automatic pop(string tag);           step(0,1,0,0,0,0,0,0,0,tag); endtask
  task automatic idle(string tag);          step(0,0,0,0,0,0,0,0,0,tag); endtask
  task automatic setptr(int v, string tag); step(0,0,1,v,0,0,0,0,0,tag); endtask
  task automatic patch(int we, int d, string tag); step(0,0,0,0,we,d,0,0,0,tag); endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst = 1;
    m_ptr = 0; m_ovf = 0; m_unf = 0; m_pv = 0; m_pa = 0;
    for (int i = 1; i <= DEPTH; i++) m_mem[i] = 0;
    repeat (3) @(negedge clk);
    compare("R1");
    rst = 0;
    idle("R1");

    // R2: pushes of varied values
    for (int i = 1; i <= 5; i++) push('h2000 + i * 'h3A5C7, "R2");
    // R3: pops hand back the top entry
    pop("R3");
    pop("R3");
    // R9: lane writes on the top entry, one lane at a time and all together
    patch(1, 'h5A, "R9");
    patch(2, 'hC3, "R9");
    patch(4, 'hFF, "R9");
    patch(7, 'h81, "R9");
    patch(5, 'h26, "R9");
    // R8: window layout after patching, then a pop returns the patched entry
    idle("R8");
    pop("R3");
    pop("R3");
    pop("R3");
    // R5: pops at empty
    pop("R5");
    pop("R5");
    // R7: underflow stays until cleared; a clear with a fresh underflow keeps it
    idle("R7");
    step(0,0,0,0,0,0,0,1,0,"R7");
    step(0,1,0,0,0,0,0,1,0,"R7");
    step(0,0,0,0,0,0,0,1,0,"R7");
    // R9: lane write at empty changes nothing; R10: pointer write exposes entry 1
    patch(7, 'hEE, "R9");
    setptr(1, "R10");
    setptr(3, "R10");
    setptr(0, "R10");
    // R12, R6: fill the stack completely
    for (int i = 1; i <= DEPTH; i++) push((i * 'h0F0F3 + 'h11) & 'h1FFFFF, "R12");
    // R4: pushes at full
    push('h1ABCD, "R4");
    push('h00042, "R4");
    idle("R7");
    step(0,0,0,0,0,0,1,0,0,"R7");
    step(1,0,0,0,0,0,1,0,'h777,"R7");
    step(0,0,0,0,0,0,1,0,0,"R7");
    // R11: priority among simultaneous requests
    step(1,1,1,20,7,'h99,0,0,'h12345,"R11");
    step(1,1,0,0,0,0,0,0,'h0BEEF,"R11");
    step(0,1,0,0,3,'h44,0,0,0,"R11");
    setptr(21, "R11");
    step(0,0,0,0,0,0,0,0,0,"R11");
    setptr(31, "R10");
    // R12: drain in reverse order
    for (int i = 0; i < DEPTH; i++) pop("R12");
    pop("R5");
    idle("R6");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule